// File: doc/BRIEF.md
# Audio Codec Control Register Bank

This block is the control register file of a multi-codec-capable audio codec. A host reaches it through a plain synchronous port: a 7-bit even index, 16-bit write data, a write strobe and a read strobe. Each implemented index holds a 16-bit control word. These words cover mixer gains and mutes, tone, record routing, power-down, digital-output setup and a small vendor field. A few indices are constants or are computed from pins.

Two active-low strap pins and a mode-select pin set the codec's identity in a multi-codec system. The identity picks which serial-link slots feed the left and right PCM converters, and it is reported in a read-only identification word. Writing any value to index 00h is a software reset. It returns the bank to its defaults but keeps the four low power-status bits of index 26h. The decoded pin-function select, clock-output enable, codec ID and slot numbers leave the block as plain wires for the neighbouring logic.

Top module: `acr_ctrl_bank`

## Requirements
- R1: After the asynchronous reset (rst_n low), every implemented register holds its default value, and index 26h holds 0000h.
- R2: Defaults: 7Ch=594Dh, 7Eh=4800h, 00h reads 0040h, 62h=0224h, 68h=0C00h, 08h=0707h, 0Ch and 0Eh=8008h, each of 10h/12h/14h/16h/18h=8808h, 02h/06h/1Ch=8000h, all other implemented registers 0000h.
- R3: A write to a writable index stores the write data ANDed with that index's mask; the other bits read as the default bits outside the mask. Masks: 02h BF3Fh; 06h 803Fh; 08h and 1Ah 0707h; 0Ah 801Eh; 0Ch 801Fh; 0Eh 805Fh; 10h-18h 9F1Fh; 1Ch 8F0Fh; 20h A380h; 22h 0E00h; 26h BF0Fh; 66h FFFFh; 68h 0C00h; 62h 0006h.
- R4: When rd_en is high at a clock edge, rd_data shows the addressed word from the next cycle on. It is the value from before any write in that same cycle. While rd_en is low, rd_data holds its value.
- R5: codec_id is the bitwise inverse of {id_strap1_n, id_strap0_n}: an open (high) pin gives 0 and a grounded pin gives 1. When id_force_primary is high, codec_id is 00.
- R6: dac_slot_left/dac_slot_right are 3/4 for codec IDs 00 and 01, 7/8 for ID 10 and 6/9 for ID 11.
- R7: Index 28h is read-only. Bits 15:14 are codec_id and bit 9 is 1. Bit 8 is set only for ID 11, bit 7 only for ID 10 and bit 6 only for ID 11. All other bits are 0.
- R8: In index 62h only bit 2 and bit 1 can be written. dig_out_sel follows bit 2 (0 selects the amplifier power-down output, 1 the digital audio output). clk_out_en follows bit 1 (0 drives the clock pin low, 1 outputs the clock). Both outputs change in the cycle after the write.
- R9: A write of any value to index 00h restores every register to its R2 default in the next cycle, except bits 3:0 of index 26h, which keep their value.
- R10: Indices 5Ah and 60h ignore writes and read as 0000h.
- R11: Odd indices and unimplemented indices read as 0000h, and writes to them change no register. Writes to 28h, 7Ch and 7Eh are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | 7 | Register index |
| wr_data | input | 16 | Write data |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| rd_data | output | 16 | Registered read data |
| id_strap0_n | input | 1 | Low ID strap, active low |
| id_strap1_n | input | 1 | High ID strap, active low |
| id_force_primary | input | 1 | Forces codec ID 00 when high |
| codec_id | output | 2 | Decoded codec ID |
| dac_slot_left | output | 4 | Slot feeding the left DAC |
| dac_slot_right | output | 4 | Slot feeding the right DAC |
| dig_out_sel | output | 1 | Shared pin function select |
| clk_out_en | output | 1 | Clock output enable |

## Verification
A stored word with a wrong bit shows up only when its index is read. The error therefore appears on rd_data one cycle after the read strobe. The bench reads every index back often, and it reads each index right after a software reset. A wrong vendor word reaches dig_out_sel and clk_out_en in the cycle after the write. A wrong ID or slot decode is combinational and shows at once on the ID and slot outputs and in the 28h word.

// File: rtl/acr_pkg.sv
package acr_pkg;
    localparam int ADDR_W  = 7;
    localparam int DATA_W  = 16;
    localparam int IDX_W   = ADDR_W - 1;
    localparam int NUM_IDX = 1 << IDX_W;
    localparam int SLOT_W  = 4;

    typedef logic [DATA_W-1:0] word_t;
    typedef logic [IDX_W-1:0]  idx_t;

    typedef enum logic [2:0] {
        K_NONE,
        K_RW,
        K_CONST,
        K_SRST,
        K_EXTID
    } kind_e;

    typedef struct packed {
        logic [NUM_IDX-1:0][DATA_W-1:0] w;
    } store_t;

    typedef struct packed {
        word_t data;
    } rd_state_t;

    localparam idx_t  IDX_SRST  = idx_t'(6'h00);
    localparam idx_t  IDX_PWR   = idx_t'(6'h13);
    localparam idx_t  IDX_EXTID = idx_t'(6'h14);
    localparam idx_t  IDX_VEND  = idx_t'(6'h31);
    localparam word_t PWR_KEEP  = 16'h000F;
    localparam word_t SRST_WORD = 16'h0040;
    localparam int    VEND_SEL_BIT = 2;
    localparam int    VEND_CLK_BIT = 1;

    function automatic kind_e idx_kind(input idx_t idx);
        case (idx)
            6'h00:  return K_SRST;
            6'h14:  return K_EXTID;
            6'h3E, 6'h3F: return K_CONST;
            6'h01, 6'h03, 6'h04, 6'h05, 6'h06, 6'h07,
            6'h08, 6'h09, 6'h0A, 6'h0B, 6'h0C, 6'h0D,
            6'h0E, 6'h10, 6'h11, 6'h13, 6'h31, 6'h33,
            6'h34:  return K_RW;
            default: return K_NONE;
        endcase
    endfunction

    function automatic word_t idx_default(input idx_t idx);
        case (idx)
            6'h00:               return SRST_WORD;
            6'h01, 6'h03, 6'h0E: return 16'h8000;
            6'h04:               return 16'h0707;
            6'h06, 6'h07:        return 16'h8008;
            6'h08, 6'h09, 6'h0A,
            6'h0B, 6'h0C:        return 16'h8808;
            6'h31:               return 16'h0224;
            6'h34:               return 16'h0C00;
            6'h3E:               return 16'h594D;
            6'h3F:               return 16'h4800;
            default:             return 16'h0000;
        endcase
    endfunction

    function automatic word_t idx_wmask(input idx_t idx);
        case (idx)
            6'h01:               return 16'hBF3F;
            6'h03:               return 16'h803F;
            6'h04, 6'h0D:        return 16'h0707;
            6'h05:               return 16'h801E;
            6'h06:               return 16'h801F;
            6'h07:               return 16'h805F;
            6'h08, 6'h09, 6'h0A,
            6'h0B, 6'h0C:        return 16'h9F1F;
            6'h0E:               return 16'h8F0F;
            6'h10:               return 16'hA380;
            6'h11:               return 16'h0E00;
            6'h13:               return 16'hBF0F;
            6'h31:               return 16'h0006;
            6'h33:               return 16'hFFFF;
            6'h34:               return 16'h0C00;
            default:             return 16'h0000;
        endcase
    endfunction

    function automatic store_t reset_image();
        store_t img;
        for (int i = 0; i < NUM_IDX; i++) begin
            img.w[i] = (idx_kind(idx_t'(i)) == K_RW) ? idx_default(idx_t'(i)) : '0;
        end
        return img;
    endfunction
endpackage

// File: rtl/acr_id_map.sv
module acr_id_map
    import acr_pkg::*;
(
    input  logic              strap0_n,
    input  logic              strap1_n,
    input  logic              force_primary,
    output logic [1:0]        id,
    output logic [SLOT_W-1:0] slot_l,
    output logic [SLOT_W-1:0] slot_r,
    output word_t             ext_id
);
    logic [1:0] id_c;
    logic       lfe_dac, sur_dac, ctr_dac;

    always_comb begin
        id_c = force_primary ? 2'b00 : {~strap1_n, ~strap0_n};
        case (id_c)
            2'b10:   begin slot_l = SLOT_W'(7); slot_r = SLOT_W'(8); end
            2'b11:   begin slot_l = SLOT_W'(6); slot_r = SLOT_W'(9); end
            default: begin slot_l = SLOT_W'(3); slot_r = SLOT_W'(4); end
        endcase
        sur_dac = (id_c == 2'b10);
        lfe_dac = (id_c == 2'b11);
        ctr_dac = (id_c == 2'b11);
        ext_id  = '0;
        ext_id[15:14] = id_c;
        ext_id[9]     = 1'b1;
        ext_id[8]     = lfe_dac;
        ext_id[7]     = sur_dac;
        ext_id[6]     = ctr_dac;
        id = id_c;
    end
endmodule

// File: rtl/acr_reg_store.sv
module acr_reg_store
    import acr_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   wr_en,
    input  idx_t   wr_idx,
    input  word_t  wr_data,
    output store_t regs
);
    store_t st_d, st_q;

    always_comb begin
        word_t mask;
        word_t dflt;
        st_d = st_q;
        mask = idx_wmask(wr_idx);
        dflt = idx_default(wr_idx);
        if (wr_en) begin
            case (idx_kind(wr_idx))
                K_RW: st_d.w[wr_idx] = (dflt & ~mask) | (wr_data & mask);
                K_SRST: begin
                    st_d = reset_image();
                    st_d.w[IDX_PWR] = (st_d.w[IDX_PWR] & ~PWR_KEEP)
                                    | (st_q.w[IDX_PWR] & PWR_KEEP);
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= reset_image();
        else        st_q <= st_d;
    end

    assign regs = st_q;
endmodule

// File: rtl/acr_ctrl_bank.sv
module acr_ctrl_bank
    import acr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              wr_en,
    input  logic              rd_en,
    output logic [DATA_W-1:0] rd_data,
    input  logic              id_strap0_n,
    input  logic              id_strap1_n,
    input  logic              id_force_primary,
    output logic [1:0]        codec_id,
    output logic [SLOT_W-1:0] dac_slot_left,
    output logic [SLOT_W-1:0] dac_slot_right,
    output logic              dig_out_sel,
    output logic              clk_out_en
);
    idx_t      idx;
    logic      even;
    store_t    regs;
    word_t     ext_id;
    rd_state_t rd_d, rd_q;

    assign idx  = addr[ADDR_W-1:1];
    assign even = ~addr[0];

    acr_id_map u_id (
        .strap0_n      (id_strap0_n),
        .strap1_n      (id_strap1_n),
        .force_primary (id_force_primary),
        .id            (codec_id),
        .slot_l        (dac_slot_left),
        .slot_r        (dac_slot_right),
        .ext_id        (ext_id)
    );

    acr_reg_store u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en & even),
        .wr_idx  (idx),
        .wr_data (wr_data),
        .regs    (regs)
    );

    always_comb begin
        word_t look;
        case (idx_kind(idx))
            K_SRST:  look = SRST_WORD;
            K_EXTID: look = ext_id;
            K_CONST: look = idx_default(idx);
            K_RW:    look = regs.w[idx];
            default: look = '0;
        endcase
        if (!even) look = '0;
        rd_d = rd_q;
        if (rd_en) rd_d.data = look;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rd_q <= '0;
        else        rd_q <= rd_d;
    end

    assign rd_data     = rd_q.data;
    assign dig_out_sel = regs.w[IDX_VEND][VEND_SEL_BIT];
    assign clk_out_en  = regs.w[IDX_VEND][VEND_CLK_BIT];
endmodule

// File: rtl/acr_ctrl_bank_chk.sv
module acr_ctrl_bank_chk
    import acr_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] addr,
    input logic [DATA_W-1:0] wr_data,
    input logic              wr_en,
    input logic              rd_en,
    input logic [DATA_W-1:0] rd_data,
    input logic              id_strap0_n,
    input logic              id_strap1_n,
    input logic              id_force_primary,
    input logic [1:0]        codec_id,
    input logic [SLOT_W-1:0] dac_slot_left,
    input logic [SLOT_W-1:0] dac_slot_right,
    input logic              dig_out_sel,
    input logic              clk_out_en
);
    a_r8_vend_write: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == 7'h62) |=>
        (dig_out_sel == $past(wr_data[2]) && clk_out_en == $past(wr_data[1])));

    a_r9_soft_reset: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == 7'h00) |=> (dig_out_sel && !clk_out_en));

    a_r11_vid_const: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && addr == 7'h7C) |=> (rd_data == 16'h594D));

    a_r10_test_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && (addr == 7'h5A || addr == 7'h60)) |=> (rd_data == 16'h0000));

    a_r11_odd_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && addr[0]) |=> (rd_data == 16'h0000));

    a_r4_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> $stable(rd_data));

    a_r5_force: assert property (@(posedge clk) disable iff (!rst_n)
        id_force_primary |-> (codec_id == 2'b00));

    a_r6_slots: assert property (@(posedge clk) disable iff (!rst_n)
        (codec_id == 2'b11) |-> (dac_slot_left == 4'd6 && dac_slot_right == 4'd9));

    a_r8_vend_stable: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> ($stable(dig_out_sel) && $stable(clk_out_en)));
endmodule

bind acr_ctrl_bank acr_ctrl_bank_chk u_chk (.*);

// File: tb/sim_acr_ctrl_bank.sv
module sim_acr_ctrl_bank;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [6:0]  addr = '0;
    logic [15:0] wr_data = '0;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [15:0] rd_data;
    logic        id_strap0_n = 1'b1;
    logic        id_strap1_n = 1'b1;
    logic        id_force_primary = 1'b0;
    logic [1:0]  codec_id;
    logic [3:0]  dac_slot_left, dac_slot_right;
    logic        dig_out_sel, clk_out_en;

    int errors = 0;
    int checks = 0;
    logic [15:0] mem [0:127];

    always #(CLK_PERIOD/2) clk = ~clk;

    acr_ctrl_bank u0 (.*);

    function automatic bit b_rw(input logic [6:0] a);
        case (a)
            7'h02, 7'h06, 7'h08, 7'h0A, 7'h0C, 7'h0E, 7'h10, 7'h12, 7'h14,
            7'h16, 7'h18, 7'h1A, 7'h1C, 7'h20, 7'h22, 7'h26, 7'h62, 7'h66,
            7'h68: return 1'b1;
            default: return 1'b0;
        endcase
    endfunction

    function automatic logic [15:0] b_def(input logic [6:0] a);
        case (a)
            7'h02, 7'h06, 7'h1C: return 16'h8000;
            7'h08: return 16'h0707;
            7'h0C, 7'h0E: return 16'h8008;
            7'h10, 7'h12, 7'h14, 7'h16, 7'h18: return 16'h8808;
            7'h62: return 16'h0224;
            7'h68: return 16'h0C00;
            default: return 16'h0000;
        endcase
    endfunction

    function automatic logic [15:0] b_mask(input logic [6:0] a);
        case (a)
            7'h02: return 16'hBF3F;
            7'h06: return 16'h803F;
            7'h08, 7'h1A: return 16'h0707;
            7'h0A: return 16'h801E;
            7'h0C: return 16'h801F;
            7'h0E: return 16'h805F;
            7'h10, 7'h12, 7'h14, 7'h16, 7'h18: return 16'h9F1F;
            7'h1C: return 16'h8F0F;
            7'h20: return 16'hA380;
            7'h22: return 16'h0E00;
            7'h26: return 16'hBF0F;
            7'h62: return 16'h0006;
            7'h66: return 16'hFFFF;
            7'h68: return 16'h0C00;
            default: return 16'h0000;
        endcase
    endfunction

    function automatic logic [1:0] b_id();
        return id_force_primary ? 2'b00 : {~id_strap1_n, ~id_strap0_n};
    endfunction

    function automatic logic [15:0] b_ext();
        logic [1:0] id = b_id();
        logic [15:0] v = 16'h0200;
        v[15:14] = id;
        v[8] = (id == 2'b11);
        v[7] = (id == 2'b10);
        v[6] = (id == 2'b11);
        return v;
    endfunction

    function automatic logic [15:0] b_read(input logic [6:0] a);
        if (a == 7'h00) return 16'h0040;
        if (a == 7'h28) return b_ext();
        if (a == 7'h7C) return 16'h594D;
        if (a == 7'h7E) return 16'h4800;
        if (b_rw(a)) return mem[a];
        return 16'h0000;
    endfunction

    task automatic model_reset(input bit keep_pwr);
        logic [3:0] keep = mem[7'h26][3:0];
        for (int i = 0; i < 128; i++) mem[i] = b_rw(7'(i)) ? b_def(7'(i)) : 16'h0000;
        if (keep_pwr) mem[7'h26][3:0] = keep;
    endtask

    task automatic model_write(input logic [6:0] a, input logic [15:0] d);
        if (a == 7'h00) model_reset(1'b1);
        else if (b_rw(a)) mem[a] = (b_def(a) & ~b_mask(a)) | (d & b_mask(a));
    endtask

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic do_write(input logic [6:0] a, input logic [15:0] d);
        @(negedge clk);
        addr = a; wr_data = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
        model_write(a, d);
    endtask

    task automatic do_read(input logic [6:0] a, input string req);
        logic [15:0] exp;
        @(negedge clk);
        addr = a; rd_en = 1'b1;
        exp = b_read(a);
        @(negedge clk);
        rd_en = 1'b0;
        check(req, {16'h0, rd_data}, {16'h0, exp});
    endtask

    task automatic check_pins(input string req);
        logic [1:0] id = b_id();
        logic [3:0] l, r;
        #1;
        case (id)
            2'b10: begin l = 4'd7; r = 4'd8; end
            2'b11: begin l = 4'd6; r = 4'd9; end
            default: begin l = 4'd3; r = 4'd4; end
        endcase
        check(req, {30'h0, codec_id}, {30'h0, id});
        check(req, {24'h0, dac_slot_left, dac_slot_right}, {24'h0, l, r});
    endtask

    initial begin
        #(CLK_PERIOD * 190000);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    localparam logic [6:0] PICK [0:27] = '{
        7'h00, 7'h02, 7'h06, 7'h08, 7'h0A, 7'h0C, 7'h0E, 7'h10, 7'h12, 7'h14,
        7'h16, 7'h18, 7'h1A, 7'h1C, 7'h20, 7'h22, 7'h26, 7'h28, 7'h5A, 7'h60,
        7'h62, 7'h66, 7'h68, 7'h7C, 7'h7E, 7'h04, 7'h03, 7'h2A};

    initial begin
        logic [15:0] held;
        void'($urandom(32'd4242));
        model_reset(1'b0);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 R2: reset state of every index
        for (int a = 0; a < 128; a += 2) do_read(7'(a), "R1_R2_reset_default");
        check("R8_reset_pins", {30'h0, dig_out_sel, clk_out_en}, 32'h2);

        // R3: masked writes
        do_write(7'h02, 16'hFFFF);
        do_read(7'h02, "R3_mask_02");
        do_write(7'h26, 16'hFFFF);
        do_read(7'h26, "R3_mask_26");

        // R4: read in the same cycle as a write returns the old word
        @(negedge clk);
        addr = 7'h1C; wr_data = 16'h0F0F; wr_en = 1'b1; rd_en = 1'b1;
        held = b_read(7'h1C);
        @(negedge clk);
        wr_en = 1'b0; rd_en = 1'b0;
        model_write(7'h1C, 16'h0F0F);
        check("R4_read_before_write", {16'h0, rd_data}, {16'h0, held});
        do_read(7'h1C, "R4_after_write");
        held = rd_data;
        @(negedge clk); addr = 7'h02;
        repeat (3) @(negedge clk);
        check("R4_hold", {16'h0, rd_data}, {16'h0, held});

        // R8: vendor word
        do_write(7'h62, 16'hFFFF);
        check("R8_pins_set", {30'h0, dig_out_sel, clk_out_en}, 32'h3);
        do_read(7'h62, "R8_vendor_read");
        do_write(7'h62, 16'h0000);
        check("R8_pins_clear", {30'h0, dig_out_sel, clk_out_en}, 32'h0);

        // R9: software reset keeps 26h low bits
        do_write(7'h00, 16'h1234);
        check("R9_pins_default", {30'h0, dig_out_sel, clk_out_en}, 32'h2);
        do_read(7'h26, "R9_pwr_keep");
        do_read(7'h02, "R9_restore_02");
        do_read(7'h1C, "R9_restore_1C");

        // R10 R11: ignored locations
        do_write(7'h5A, 16'hFFFF);
        do_read(7'h5A, "R10_5A");
        do_write(7'h60, 16'hFFFF);
        do_read(7'h60, "R10_60");
        do_write(7'h28, 16'hFFFF);
        do_read(7'h28, "R11_28_readonly");
        do_write(7'h7C, 16'h0000);
        do_read(7'h7C, "R11_7C_readonly");
        do_write(7'h03, 16'hFFFF);
        do_read(7'h02, "R11_odd_write_ignored");
        do_read(7'h03, "R11_odd_read");

        // R5 R6 R7: all strap combinations and the force input
        for (int f = 0; f < 2; f++) begin
            for (int s = 0; s < 4; s++) begin
                @(negedge clk);
                id_force_primary = f[0];
                {id_strap1_n, id_strap0_n} = s[1:0];
                check_pins("R5_R6_id_slots");
                do_read(7'h28, "R7_ext_id");
            end
        end

        // Random mix of writes and reads, R3 R7 R9 R11
        for (int n = 0; n < 600; n++) begin
            logic [6:0] a;
            a = ($urandom % 4 == 0) ? 7'($urandom) : PICK[$urandom % 28];
            if ($urandom % 16 == 0) begin
                @(negedge clk);
                {id_force_primary, id_strap1_n, id_strap0_n} = 3'($urandom);
                check_pins("R5_R6_random");
            end
            if ($urandom % 2 == 0) begin
                if (a == 7'h00 && $urandom % 6 != 0) a = 7'h26;
                do_write(a, 16'($urandom));
            end else begin
                do_read(a, "R3_R7_R11_random");
            end
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule